// File: doc/BRIEF.md
# Serial ADC Conversion Read Sequencer

This block is the host (master) side of one conversion on a serial ADC link. The link uses clock polarity 0 and phase 0. A one-cycle start request is accepted only while the block is idle. The block then pulls chip select low and clocks out 24 bits as three bytes. The first byte is a configuration byte with a leading one. It carries the channel number, the input-range selection, the input-type selection and the power mode. The next two bytes are zero, and while they are sent the converter returns its result.

When the last bit has been exchanged, the block waits half a serial clock period and releases chip select. It then issues a single-cycle done pulse. With the pulse it presents the 12-bit result taken from the returned data and a flag saying whether the conversion was bipolar. The serial clock comes from a programmable half-period divider of the system clock, so software can keep it inside the converter's allowed 500 kHz to 4.8 MHz band.

A frame-length limit, counted in system clocks, guards against sample-and-hold droop. A frame whose chip-select-low time exceeds the limit raises a timeout flag. The flag stays set until the next start is accepted.

Top module: `adc_read_seq`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and done, busy and timeout are all low.
- R2: The first 8 bits driven on mosi, MSB first, are {1, chan[2:0], unipolar, single_ended, pwr_mode[1:0]}, as sampled on the start cycle.
- R3: The mosi bits 9 through 24 of a frame are all zero.
- R4: Each frame has exactly 24 rising serial clock edges. The serial clock is low whenever chip select is high, and chip select stays low for every rising edge.
- R5: Every high and low phase of the serial clock lasts H system clocks, where H = half_div, or 1 when half_div is 0. The time from chip select falling to the first rising edge, and from the last falling edge to chip select rising, is also H system clocks.
- R6: The received bits are numbered 23 (first) down to 0 (last). The result equals bits 12 down to 1. Bits 23 to 13 and bit 0 have no effect on the result.
- R7: Done is a one-cycle pulse issued in the cycle in which chip select has returned high. Exactly one pulse is issued per frame. In that cycle, result_bipolar equals the inverse of the unipolar input captured at start.
- R8: A start request during a busy frame is ignored: the frame keeps its control byte, it has 24 rising edges, and no second frame follows.
- R9: The chip-select-low time of a frame is 49*H system clocks. At the done pulse, timeout is 1 exactly when 49*H > frame_limit. The flag is cleared by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request, accepted when idle |
| chan | input | 3 | Channel number for the control byte |
| unipolar | input | 1 | 1 = unipolar range, 0 = bipolar |
| single_ended | input | 1 | 1 = single-ended input, 0 = differential |
| pwr_mode | input | 2 | Power-mode field for the control byte |
| half_div | input | DIV_W | Serial clock half period in system clocks (0 acts as 1) |
| frame_limit | input | TMR_W | Largest allowed chip-select-low time in system clocks |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the converter |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 12 | Extracted conversion result |
| result_bipolar | output | 1 | Bipolar flag of the completed conversion |
| timeout | output | 1 | Frame exceeded frame_limit |

## Verification
The control path is swept over all 128 combinations of channel, range, input type and power mode at the fastest divider. Each combination returns a different result word with non-zero filler bits, so a swapped field or an off-by-one extraction shows up. A walking-one pattern and the all-zero and all-one words at slower dividers tell apart bit-order faults from faults in phase timing. The timeout flag is tested on both sides of the 49*H boundary for three divider values, which catches off-by-one errors in the frame counter. A start pulsed mid-frame, and a divider of zero, cover the ignore rule and the divider's floor.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CTRL_BITS  = 8;
    localparam int FRAME_BITS = 24;
    localparam int RES_BITS   = 12;
    localparam int RES_LSB    = 1;
    localparam int BIT_CNT_W  = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_TRAIL
    } seq_state_t;

    typedef struct packed {
        seq_state_t            state;
        logic [BIT_CNT_W-1:0]  bit_idx;
        logic                  cs_n;
        logic                  sclk;
        logic                  done;
        logic [RES_BITS-1:0]   result;
        logic                  bipolar;
    } seq_regs_t;

endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             en,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] lim;
    } div_regs_t;

    div_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        tick  = en && (cur_q.cnt == cur_q.lim - DIV_W'(1));
        if (restart) begin
            nxt_d.lim = (half_div == '0) ? DIV_W'(1) : half_div;
            nxt_d.cnt = '0;
        end else if (!en || tick) begin
            nxt_d.cnt = '0;
        end else begin
            nxt_d.cnt = cur_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.cnt <= '0;
            cur_q.lim <= DIV_W'(1);
        end else begin
            cur_q <= nxt_d;
        end
    end

    // R5: the phase counter never runs past the latched half period
    a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt < cur_q.lim);

    // R5: the latched limit is never zero
    a_r5_lim_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.lim != '0);

endmodule

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter
    import adc_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [CTRL_BITS-1:0]  ctrl_byte,
    input  logic                  shift,
    input  logic                  sample,
    input  logic                  miso,
    output logic                  mosi,
    output logic [FRAME_BITS-1:0] rx_word
);

    typedef struct packed {
        logic [FRAME_BITS-1:0] tx;
        logic [FRAME_BITS-1:0] rx;
    } sh_regs_t;

    sh_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.tx = {ctrl_byte, {(FRAME_BITS-CTRL_BITS){1'b0}}};
            nxt_d.rx = '0;
        end else begin
            if (shift) begin
                nxt_d.tx = {cur_q.tx[FRAME_BITS-2:0], 1'b0};
            end
            if (sample) begin
                nxt_d.rx = {cur_q.rx[FRAME_BITS-2:0], miso};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mosi    = cur_q.tx[FRAME_BITS-1];
    assign rx_word = cur_q.rx;

    // R4: sampling (rising edge) and shifting (falling edge) never coincide
    a_r4_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift && sample));

    // R2: a loaded frame starts with the start bit on the line
    a_r2_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> mosi);

endmodule

// File: rtl/adc_seq_frame_timer.sv
module adc_seq_frame_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [TMR_W-1:0] frame_limit,
    output logic             over
);

    localparam logic [TMR_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
        logic [TMR_W-1:0] lim;
        logic             over;
    } tmr_regs_t;

    tmr_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (clr) begin
            nxt_d.cnt  = '0;
            nxt_d.lim  = frame_limit;
            nxt_d.over = 1'b0;
        end else if (en) begin
            if (cur_q.cnt >= cur_q.lim) begin
                nxt_d.over = 1'b1;
            end
            if (cur_q.cnt != CNT_MAX) begin
                nxt_d.cnt = cur_q.cnt + TMR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign over = cur_q.over;

    // R9: once raised inside a frame, the flag stays until a new start
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.over && !clr) |=> cur_q.over);

    // R9: a new start clears the flag
    a_r9_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !cur_q.over);

endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq
    import adc_seq_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int TMR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [2:0]          chan,
    input  logic                unipolar,
    input  logic                single_ended,
    input  logic [1:0]          pwr_mode,
    input  logic [DIV_W-1:0]    half_div,
    input  logic [TMR_W-1:0]    frame_limit,
    input  logic                miso,
    output logic                cs_n,
    output logic                sclk,
    output logic                mosi,
    output logic                busy,
    output logic                done,
    output logic [RES_BITS-1:0] result,
    output logic                result_bipolar,
    output logic                timeout
);

    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(FRAME_BITS - 1);

    seq_regs_t cur_q, nxt_d;

    logic                  accept;
    logic                  do_shift;
    logic                  do_sample;
    logic                  tick;
    logic                  active;
    logic [FRAME_BITS-1:0] rx_word;
    logic [CTRL_BITS-1:0]  ctrl_byte;

    assign active    = (cur_q.state != ST_IDLE);
    assign ctrl_byte = {1'b1, chan, unipolar, single_ended, pwr_mode};

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        accept     = 1'b0;
        do_shift   = 1'b0;
        do_sample  = 1'b0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (start) begin
                    accept        = 1'b1;
                    nxt_d.state   = ST_LOW;
                    nxt_d.cs_n    = 1'b0;
                    nxt_d.bit_idx = '0;
                    nxt_d.bipolar = ~unipolar;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    nxt_d.sclk  = 1'b1;
                    nxt_d.state = ST_HIGH;
                    do_sample   = 1'b1;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    nxt_d.sclk = 1'b0;
                    if (cur_q.bit_idx == LAST_BIT) begin
                        nxt_d.state = ST_TRAIL;
                    end else begin
                        nxt_d.bit_idx = cur_q.bit_idx + BIT_CNT_W'(1);
                        nxt_d.state   = ST_LOW;
                        do_shift      = 1'b1;
                    end
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    nxt_d.cs_n   = 1'b1;
                    nxt_d.done   = 1'b1;
                    nxt_d.result = rx_word[RES_LSB +: RES_BITS];
                    nxt_d.state  = ST_IDLE;
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state   <= ST_IDLE;
            cur_q.bit_idx <= '0;
            cur_q.cs_n    <= 1'b1;
            cur_q.sclk    <= 1'b0;
            cur_q.done    <= 1'b0;
            cur_q.result  <= '0;
            cur_q.bipolar <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    adc_seq_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (accept),
        .en       (active),
        .half_div (half_div),
        .tick     (tick)
    );

    adc_seq_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .ctrl_byte (ctrl_byte),
        .shift     (do_shift),
        .sample    (do_sample),
        .miso      (miso),
        .mosi      (mosi),
        .rx_word   (rx_word)
    );

    adc_seq_frame_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (accept),
        .en          (active),
        .frame_limit (frame_limit),
        .over        (timeout)
    );

    assign cs_n           = cur_q.cs_n;
    assign sclk           = cur_q.sclk;
    assign busy           = active;
    assign done           = cur_q.done;
    assign result         = cur_q.result;
    assign result_bipolar = cur_q.bipolar;

    // R4: the serial clock is low whenever chip select is released
    a_r4_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R4: chip select cannot rise directly out of a high clock phase
    a_r4_cs_held_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> !cs_n);

    // R7: done lasts exactly one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done appears only with chip select high
    a_r7_done_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);

    // R8: a start while busy does not disturb the current frame
    a_r8_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && cur_q.state != ST_TRAIL) |=> busy);

endmodule

// File: tb/adc_read_seq_test.sv
module adc_read_seq_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [2:0]  chan;
    logic        unipolar;
    logic        single_ended;
    logic [1:0]  pwr_mode;
    logic [7:0]  half_div;
    logic [15:0] frame_limit;
    logic        miso;
    logic        cs_n, sclk, mosi, busy, done, result_bipolar, timeout;
    logic [11:0] result;

    always #5 clk = ~clk;

    adc_read_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .chan(chan),
        .unipolar(unipolar), .single_ended(single_ended), .pwr_mode(pwr_mode),
        .half_div(half_div), .frame_limit(frame_limit), .miso(miso),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .busy(busy), .done(done),
        .result(result), .result_bipolar(result_bipolar), .timeout(timeout)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // converter model: first bit at chip-select fall, next bits after each falling clock
    logic [23:0] sl_word;
    logic [23:0] sl_sh;
    always @(negedge cs_n) begin
        sl_sh = sl_word;
        miso  = sl_sh[23];
    end
    always @(negedge sclk) begin
        if (!cs_n) begin
            sl_sh = {sl_sh[22:0], 1'b0};
            miso  = sl_sh[23];
        end
    end

    // capture of mosi and edge counts
    logic [23:0] mosi_cap;
    int rises, cs_bad;
    always @(posedge sclk) begin
        mosi_cap = {mosi_cap[22:0], mosi};
        rises++;
        if (cs_n) cs_bad++;
    end

    // phase length and done monitor
    int exp_h, run, run_bad, done_cnt;
    bit prev_in, prev_sclk, done_cs;
    always @(negedge clk) begin
        if (!cs_n) begin
            if (prev_in && sclk == prev_sclk) run++;
            else begin
                if (prev_in && run != exp_h) run_bad++;
                run = 1;
            end
        end else if (prev_in) begin
            if (run != exp_h) run_bad++;
        end
        prev_in   = !cs_n;
        prev_sclk = sclk;
        if (done) begin
            done_cnt++;
            done_cs = cs_n;
        end
    end

    task automatic run_frame(input int h, input int lim, input logic [2:0] ch,
                             input bit uni, input bit sgl, input logic [1:0] pw,
                             input logic [11:0] val, input logic [7:0] junk,
                             input bit mid_start);
        int eff;
        bit seen;
        logic [7:0] ctrl;
        eff  = (h == 0) ? 1 : h;
        ctrl = {1'b1, ch, uni, sgl, pw};
        @(negedge clk);
        half_div     = 8'(h);
        frame_limit  = 16'(lim);
        chan         = ch;
        unipolar     = uni;
        single_ended = sgl;
        pwr_mode     = pw;
        sl_word      = {junk, 3'b111 & junk[2:0], val, junk[7]};
        exp_h    = eff;
        rises    = 0;
        cs_bad   = 0;
        run_bad  = 0;
        done_cnt = 0;
        mosi_cap = '0;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen  = 1'b0;
        for (int i = 0; i < 60 * eff + 20 && !seen; i++) begin
            if (mid_start && i == 10) begin
                start = 1'b1;
                chan  = ~ch;
            end else begin
                start = 1'b0;
            end
            if (done) begin
                seen = 1'b1;
                check(result == val, "R6", "result", result, val);
                check(result_bipolar == !uni, "R7", "bipolar flag", result_bipolar, !uni);
                check(timeout == (49 * eff > lim), "R9", "timeout at done",
                      timeout, (49 * eff > lim));
            end else begin
                @(negedge clk);
            end
        end
        start = 1'b0;
        check(seen, "R7", "done seen", seen, 1);
        repeat (4 * eff + 6) @(negedge clk);
        check(done_cnt == 1, "R7", "done pulses", done_cnt, 1);
        check(done_cs, "R7", "cs high at done", done_cs, 1);
        check(rises == 24, mid_start ? "R8" : "R4", "rising edges", rises, 24);
        check(cs_bad == 0, "R4", "rise with cs high", cs_bad, 0);
        check(mosi_cap[23:16] == ctrl, mid_start ? "R8" : "R2", "control byte",
              mosi_cap[23:16], ctrl);
        check(mosi_cap[15:0] == 16'h0, "R3", "zero bytes", mosi_cap[15:0], 0);
        check(run_bad == 0, "R5", "phase length errors", run_bad, 0);
        check(!busy && cs_n && !sclk, "R4", "idle after frame", {busy, cs_n, sclk}, 3'b010);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; chan = '0; unipolar = 1'b0; single_ended = 1'b0;
        pwr_mode = '0; half_div = 8'd1; frame_limit = 16'hFFFF; miso = 1'b0;
        sl_word = '0; exp_h = 1; run = 0; rises = 0; cs_bad = 0; run_bad = 0;
        done_cnt = 0; prev_in = 0; prev_sclk = 0; done_cs = 0; mosi_cap = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cs_n == 1'b1, "R1", "cs_n", cs_n, 1);
        check(sclk == 1'b0, "R1", "sclk", sclk, 0);
        check(!done && !busy && !timeout, "R1", "done/busy/timeout",
              {done, busy, timeout}, 0);

        // R2 R6: full sweep of control fields at the fastest divider
        for (int k = 0; k < 128; k++) begin
            run_frame(1, 16'hFFFF, 3'(k >> 4), k[3], k[2], 2'(k),
                      12'((k * 37 + 5) & 12'hFFF), 8'((k * 91) ^ 8'hA5), 1'b0);
        end
        // R6: walking one through the result field
        for (int b = 0; b < 12; b++) begin
            run_frame(2, 16'hFFFF, 3'(b), b[0], b[1], 2'(b), 12'(1 << b), 8'hFF, 1'b0);
        end
        run_frame(3, 16'hFFFF, 3'd7, 1'b1, 1'b1, 2'd3, 12'h000, 8'hFF, 1'b0);
        run_frame(3, 16'hFFFF, 3'd0, 1'b0, 1'b0, 2'd0, 12'hFFF, 8'h00, 1'b0);
        // R5: divider value 0 acts as 1
        run_frame(0, 16'hFFFF, 3'd5, 1'b1, 1'b0, 2'd1, 12'h5A3, 8'h3C, 1'b0);
        // R9: timeout boundary on both sides
        for (int h = 1; h <= 3; h++) begin
            run_frame(h, 49 * h,     3'd2, 1'b0, 1'b1, 2'd2, 12'h123, 8'h81, 1'b0);
            run_frame(h, 49 * h - 1, 3'd3, 1'b1, 1'b0, 2'd1, 12'hABC, 8'h18, 1'b0);
        end
        // R9: flag cleared by the following start
        run_frame(2, 16'hFFFF, 3'd1, 1'b1, 1'b1, 2'd0, 12'h777, 8'h42, 1'b0);
        // R8: start pulsed mid-frame is ignored
        run_frame(2, 16'hFFFF, 3'd4, 1'b0, 1'b1, 2'd3, 12'h9E1, 8'hC3, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule